// File: doc/BRIEF.md
# Bridge Configuration Register Bank

This block holds the type-1 configuration header of a PCI-to-PCI bridge. Software reaches it through a 32-bit configuration port: a dword index, four byte enables and a write strobe. The read data is a combinational function of the dword index. The bank stores the bus numbers, the secondary latency timer, the I/O, memory and prefetchable base/limit registers with their upper-address extensions, the command word and bridge control. It also returns fixed identity and capability fields. The window decoder downstream reads the register state. It does not interpret addresses itself.

On top of plain storage the bank produces two registered, one-clock side effects. The first pulses the secondary bus reset when the reset bit in bridge control goes from 0 to 1. The second is an update strobe that tells the decoder a write touched a window-related byte. A separate forwarding-disable input closes every window in one cycle. It does this by loading all base bits with ones and all limit bits with zeros. The parameters `IO_32BIT` and `PREF_64BIT` choose whether the upper address registers can be written and what the read-only type nibbles report.

Top module: `bridge_cfg_bank`

## Requirements
- R1: While reset is held, and after it is released, the command word, bus numbers, latency timer, all base/limit bits, the prefetchable upper registers, the I/O upper registers and bridge control read as zero. Only the fixed fields and type nibbles are non-zero.
- R2: The fixed fields read as constants, and writes do not change them. Dword 0 holds the vendor and device IDs. Dword 2 holds the revision in bits 7:0 and class 0x060400 above it. Byte 0x0E reads 0x01 with bit 7 equal to `MULTI_FUNC`. Both status words (bytes 0x06 and 0x1E) read 0x00A0, which means 66 MHz capable (bit 5) and fast back-to-back capable (bit 7).
- R3: Each byte enable gates its own byte lane. A lane whose enable is low keeps its old value.
- R4: The low nibble of each base/limit byte is read-only. The I/O base (0x1C) and I/O limit (0x1D) nibbles read 1 when `IO_32BIT` is set. The memory nibbles (0x20, 0x22) read 0. The prefetchable nibbles (0x24, 0x26) read 1 when `PREF_64BIT` is set.
- R5: A cycle with `fwd_disable` high does the following in one step:
  - sets I/O base bits 7:4, memory base bits 15:4 and prefetchable base bits 15:4 to ones;
  - clears the matching limit bits;
  - zeroes both prefetchable upper registers.
  A write in the same cycle is dropped, and no strobe is raised.
- R6: `sec_bus_rst` is high for exactly the one cycle after a write that takes bridge control bit 6 (byte 0x3E, bit 6) from 0 to 1. Rewriting a 1, or clearing the bit, gives no pulse.
- R7: `win_update` is high for exactly the one cycle after a write where at least one enabled byte falls in one of these ranges: 0x04–0x05, 0x1C–0x1D, 0x20–0x33 or 0x3E–0x3F. The written value does not matter. Writes to other bytes, and writes with no enabled byte, raise nothing.
- R8: The writable bits are limited. In the command word only bits 0, 1, 2, 6 and 8 can be written. In bridge control only bits 11:0 can be written. All other bits of these two words read 0.
- R9: The primary, secondary and subordinate bus numbers (0x18–0x1A), the latency timer (0x1B), the prefetchable upper registers (0x28, 0x2C) and the I/O upper registers (0x30) are writable across their full width when their parameters allow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_dw_addr | input | 6 | Dword index into the 256-byte header |
| cfg_byte_en | input | 4 | Byte lane enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_dw_addr`, combinational |
| fwd_disable | input | 1 | Close all forwarding windows this cycle |
| sec_bus_rst | output | 1 | One-cycle secondary bus reset pulse |
| win_update | output | 1 | One-cycle strobe after a window-related write |

## Verification
Some properties hold on every cycle and are checked by assertions:
- the reset pulse only appears when the stored bridge control bit has just risen;
- the reset pulse never lasts two cycles;
- the update strobe only follows an accepted write;
- a forwarding-disable cycle leaves every window closed and the bus numbers unchanged.

Other behaviour can only be shown by the bench's scenarios. These are the write masks and read-only nibbles, the byte-lane independence, the exact byte ranges that do or do not raise the strobe, and the return to zero after a reset in the middle of a run.

// File: rtl/bcb_pkg.sv
package bcb_pkg;
  localparam int HDR_AW = 6;
  typedef logic [HDR_AW-1:0] dw_t;

  localparam dw_t DW_ID    = 6'h00;
  localparam dw_t DW_CMD   = 6'h01;
  localparam dw_t DW_CLASS = 6'h02;
  localparam dw_t DW_HDR   = 6'h03;
  localparam dw_t DW_BUS   = 6'h06;
  localparam dw_t DW_IO    = 6'h07;
  localparam dw_t DW_MEM   = 6'h08;
  localparam dw_t DW_PREF  = 6'h09;
  localparam dw_t DW_PBU   = 6'h0A;
  localparam dw_t DW_PLU   = 6'h0B;
  localparam dw_t DW_IOU   = 6'h0C;
  localparam dw_t DW_CTL   = 6'h0F;

  localparam logic [15:0] CMD_WMASK  = 16'h0147;
  localparam logic [15:0] CTL_WMASK  = 16'h0FFF;
  localparam logic [15:0] IO_WMASK   = 16'hF0F0;
  localparam logic [31:0] RNG_WMASK  = 32'hFFF0_FFF0;
  localparam logic [15:0] CAP_STATUS = 16'h00A0;
  localparam logic [23:0] CLASS_P2P  = 24'h060400;
  localparam int          CTL_SRST_BIT = 6;

  // closed-window presets
  localparam logic [15:0] IO_CLOSED  = 16'h00F0;
  localparam logic [31:0] RNG_CLOSED = 32'h0000_FFF0;

  typedef struct packed {
    logic [15:0] cmd;
    logic [31:0] bus;
    logic [15:0] io;
    logic [31:0] mem;
    logic [31:0] pref;
    logic [31:0] pbu;
    logic [31:0] plu;
    logic [31:0] iou;
    logic [15:0] ctl;
  } bank_t;

  function automatic logic [31:0] lane_mask(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  // byte addresses whose write must refresh the forwarding windows
  function automatic logic upd_span(input logic [7:0] a);
    return (a == 8'h04) || (a == 8'h05) ||
           (a == 8'h1C) || (a == 8'h1D) ||
           ((a >= 8'h20) && (a <= 8'h33)) ||
           (a == 8'h3E) || (a == 8'h3F);
  endfunction
endpackage

// File: rtl/bcb_wr_decode.sv
module bcb_wr_decode
  import bcb_pkg::*;
(
  input  logic       wr_en,
  input  logic       fwd_disable,
  input  dw_t        dw_addr,
  input  logic [3:0] byte_en,
  output logic [3:0] lane_we,
  output logic       upd_req
);
  logic [3:0] lane_hit;

  for (genvar l = 0; l < 4; l++) begin : g_lane
    logic [7:0] baddr;
    assign baddr       = {dw_addr, 2'(l)};
    assign lane_we[l]  = wr_en & ~fwd_disable & byte_en[l];
    assign lane_hit[l] = lane_we[l] & upd_span(baddr);
  end

  assign upd_req = |lane_hit;
endmodule

// File: rtl/bcb_regs.sv
module bcb_regs
  import bcb_pkg::*;
#(
  parameter bit IO_32BIT   = 1'b1,
  parameter bit PREF_64BIT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  dw_t         dw_addr,
  input  logic [3:0]  lane_we,
  input  logic [31:0] wdata,
  input  logic        fwd_disable,
  output bank_t       q,
  output logic        srst_rise
);
  localparam logic [31:0] UPPER_PREF_WMASK = PREF_64BIT ? 32'hFFFF_FFFF : 32'h0;
  localparam logic [31:0] UPPER_IO_WMASK   = IO_32BIT   ? 32'hFFFF_FFFF : 32'h0;

  bank_t       d;
  logic [31:0] cur, wm, m, nv;
  logic        en;

  // current word and writable mask of the addressed dword
  always_comb begin
    cur = 32'h0;
    wm  = 32'h0;
    case (dw_addr)
      DW_CMD:  begin cur = {16'h0, q.cmd}; wm = {16'h0, CMD_WMASK}; end
      DW_BUS:  begin cur = q.bus;          wm = 32'hFFFF_FFFF;      end
      DW_IO:   begin cur = {16'h0, q.io};  wm = {16'h0, IO_WMASK};  end
      DW_MEM:  begin cur = q.mem;          wm = RNG_WMASK;          end
      DW_PREF: begin cur = q.pref;         wm = RNG_WMASK;          end
      DW_PBU:  begin cur = q.pbu;          wm = UPPER_PREF_WMASK;   end
      DW_PLU:  begin cur = q.plu;          wm = UPPER_PREF_WMASK;   end
      DW_IOU:  begin cur = q.iou;          wm = UPPER_IO_WMASK;     end
      DW_CTL:  begin cur = {q.ctl, 16'h0}; wm = {CTL_WMASK, 16'h0}; end
      default: begin cur = 32'h0;          wm = 32'h0;              end
    endcase
    m  = lane_mask(lane_we) & wm;
    nv = (cur & ~m) | (wdata & m);
  end

  // next state
  always_comb begin
    d = q;
    if (fwd_disable) begin
      d.io   = IO_CLOSED;
      d.mem  = RNG_CLOSED;
      d.pref = RNG_CLOSED;
      d.pbu  = 32'h0;
      d.plu  = 32'h0;
    end else if (|lane_we) begin
      case (dw_addr)
        DW_CMD:  d.cmd  = nv[15:0];
        DW_BUS:  d.bus  = nv;
        DW_IO:   d.io   = nv[15:0];
        DW_MEM:  d.mem  = nv;
        DW_PREF: d.pref = nv;
        DW_PBU:  d.pbu  = nv;
        DW_PLU:  d.plu  = nv;
        DW_IOU:  d.iou  = nv;
        DW_CTL:  d.ctl  = nv[31:16];
        default: ;
      endcase
    end
  end

  assign en        = fwd_disable | (|lane_we);
  assign srst_rise = ~q.ctl[CTL_SRST_BIT] & d.ctl[CTL_SRST_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end

  AST_DISABLE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_disable |=> (q.io == IO_CLOSED) && (q.mem == RNG_CLOSED) &&
                    (q.pref == RNG_CLOSED) && (q.pbu == 32'h0) && (q.plu == 32'h0)); // R5
  AST_DISABLE_DROPS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_disable |=> (q.bus == $past(q.bus)) && (q.ctl == $past(q.ctl))); // R5
endmodule

// File: rtl/bcb_rd_mux.sv
module bcb_rd_mux
  import bcb_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'hABCD,
  parameter logic [15:0] DEVICE_ID  = 16'h5A17,
  parameter logic [7:0]  REV_ID     = 8'h03,
  parameter bit          MULTI_FUNC = 1'b1,
  parameter bit          IO_32BIT   = 1'b1,
  parameter bit          PREF_64BIT = 1'b1
) (
  input  dw_t         dw_addr,
  input  bank_t       q,
  output logic [31:0] rdata
);
  localparam logic [3:0]  IO_TYPE   = IO_32BIT   ? 4'h1 : 4'h0;
  localparam logic [3:0]  PREF_TYPE = PREF_64BIT ? 4'h1 : 4'h0;
  localparam logic [7:0]  HDR_TYPE  = {MULTI_FUNC, 7'h01};
  localparam logic [15:0] IO_NIB    = {4'h0, IO_TYPE, 4'h0, IO_TYPE};
  localparam logic [31:0] PREF_NIB  = {12'h0, PREF_TYPE, 12'h0, PREF_TYPE};

  always_comb begin
    case (dw_addr)
      DW_ID:    rdata = {DEVICE_ID, VENDOR_ID};
      DW_CMD:   rdata = {CAP_STATUS, q.cmd};
      DW_CLASS: rdata = {CLASS_P2P, REV_ID};
      DW_HDR:   rdata = {8'h00, HDR_TYPE, 16'h0000};
      DW_BUS:   rdata = q.bus;
      DW_IO:    rdata = {CAP_STATUS, q.io | IO_NIB};
      DW_MEM:   rdata = q.mem;
      DW_PREF:  rdata = q.pref | PREF_NIB;
      DW_PBU:   rdata = q.pbu;
      DW_PLU:   rdata = q.plu;
      DW_IOU:   rdata = q.iou;
      DW_CTL:   rdata = {q.ctl, 16'h0000};
      default:  rdata = 32'h0;
    endcase
  end
endmodule

// File: rtl/bcb_pulse.sv
module bcb_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic srst_rise,
  input  logic upd_req,
  output logic srst_q,
  output logic upd_q
);
  logic srst_d, upd_d;

  always_comb begin
    srst_d = srst_rise;
    upd_d  = upd_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_q <= 1'b0;
      upd_q  <= 1'b0;
    end else begin
      srst_q <= srst_d;
      upd_q  <= upd_d;
    end
  end
endmodule

// File: rtl/bridge_cfg_bank.sv
module bridge_cfg_bank
  import bcb_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'hABCD,
  parameter logic [15:0] DEVICE_ID  = 16'h5A17,
  parameter logic [7:0]  REV_ID     = 8'h03,
  parameter bit          MULTI_FUNC = 1'b1,
  parameter bit          IO_32BIT   = 1'b1,
  parameter bit          PREF_64BIT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr_en,
  input  logic [5:0]  cfg_dw_addr,
  input  logic [3:0]  cfg_byte_en,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        fwd_disable,
  output logic        sec_bus_rst,
  output logic        win_update
);
  logic       rst_meta, rst_sync;
  logic [3:0] lane_we;
  logic       upd_req, srst_rise;
  bank_t      bank_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  bcb_wr_decode i_dec (
    .wr_en      (cfg_wr_en),
    .fwd_disable(fwd_disable),
    .dw_addr    (cfg_dw_addr),
    .byte_en    (cfg_byte_en),
    .lane_we    (lane_we),
    .upd_req    (upd_req)
  );

  bcb_regs #(.IO_32BIT(IO_32BIT), .PREF_64BIT(PREF_64BIT)) i_regs (
    .clk        (clk),
    .rst_n      (rst_sync),
    .dw_addr    (cfg_dw_addr),
    .lane_we    (lane_we),
    .wdata      (cfg_wdata),
    .fwd_disable(fwd_disable),
    .q          (bank_q),
    .srst_rise  (srst_rise)
  );

  bcb_rd_mux #(
    .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .REV_ID(REV_ID),
    .MULTI_FUNC(MULTI_FUNC), .IO_32BIT(IO_32BIT), .PREF_64BIT(PREF_64BIT)
  ) i_rd (
    .dw_addr(cfg_dw_addr),
    .q      (bank_q),
    .rdata  (cfg_rdata)
  );

  bcb_pulse i_pulse (
    .clk      (clk),
    .rst_n    (rst_sync),
    .srst_rise(srst_rise),
    .upd_req  (upd_req),
    .srst_q   (sec_bus_rst),
    .upd_q    (win_update)
  );

  AST_SRST_ON_RISE: assert property (@(posedge clk) disable iff (!rst_sync)
    sec_bus_rst |-> (bank_q.ctl[CTL_SRST_BIT] && !$past(bank_q.ctl[CTL_SRST_BIT]))); // R6
  AST_SRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_sync)
    sec_bus_rst |=> !sec_bus_rst); // R6
  AST_UPD_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_sync)
    win_update |-> $past(cfg_wr_en && !fwd_disable && (|cfg_byte_en))); // R7
endmodule

// File: tb/test_bridge_cfg_bank.sv
module test_bridge_cfg_bank;
  localparam int          CLK_PERIOD = 10;
  localparam logic [15:0] VID = 16'hABCD;
  localparam logic [15:0] DID = 16'h5A17;
  localparam logic [7:0]  REV = 8'h03;

  logic        clk, rst_n, cfg_wr_en, fwd_disable;
  logic [5:0]  cfg_dw_addr;
  logic [3:0]  cfg_byte_en;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        sec_bus_rst, win_update;

  bridge_cfg_bank #(
    .VENDOR_ID(VID), .DEVICE_ID(DID), .REV_ID(REV),
    .MULTI_FUNC(1'b1), .IO_32BIT(1'b1), .PREF_64BIT(1'b1)
  ) i_bridge_cfg_bank (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_dw_addr(cfg_dw_addr),
    .cfg_byte_en(cfg_byte_en), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .fwd_disable(fwd_disable), .sec_bus_rst(sec_bus_rst), .win_update(win_update)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] st [0:63];
  bit exp_srst, exp_upd;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // writable bits per byte, from R3/R4/R8/R9
  function automatic logic [7:0] wm(input int a);
    case (a)
      8'h04: return 8'h47;
      8'h05: return 8'h01;
      8'h18, 8'h19, 8'h1A, 8'h1B: return 8'hFF;
      8'h1C, 8'h1D: return 8'hF0;
      8'h20, 8'h22, 8'h24, 8'h26: return 8'hF0;
      8'h21, 8'h23, 8'h25, 8'h27: return 8'hFF;
      8'h3E: return 8'hFF;
      8'h3F: return 8'h0F;
      default: return (a >= 8'h28 && a <= 8'h33) ? 8'hFF : 8'h00;
    endcase
  endfunction

  // constant bits per byte, from R2/R4
  function automatic logic [7:0] cn(input int a);
    case (a)
      0: return VID[7:0];
      1: return VID[15:8];
      2: return DID[7:0];
      3: return DID[15:8];
      8'h06, 8'h1E: return 8'hA0;
      8'h08: return REV;
      8'h0A: return 8'h04;
      8'h0B: return 8'h06;
      8'h0E: return 8'h81;
      8'h1C, 8'h1D, 8'h24, 8'h26: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [31:0] mread(input int dw);
    logic [31:0] r = 32'h0;
    if (dw < 16)
      for (int l = 0; l < 4; l++) r[8*l +: 8] = st[dw*4+l] | cn(dw*4+l);
    return r;
  endfunction

  task automatic mclear();
    for (int i = 0; i < 64; i++) st[i] = 8'h00;
    exp_srst = 1'b0;
    exp_upd  = 1'b0;
  endtask

  task automatic mupdate(input bit wr, input int dw, input logic [3:0] be,
                         input logic [31:0] d, input bit dis);
    bit old6 = st[8'h3E][6];
    exp_upd = 1'b0;
    if (dis) begin
      st[8'h1C] = 8'hF0; st[8'h1D] = 8'h00;
      st[8'h20] = 8'hF0; st[8'h21] = 8'hFF; st[8'h22] = 8'h00; st[8'h23] = 8'h00;
      st[8'h24] = 8'hF0; st[8'h25] = 8'hFF; st[8'h26] = 8'h00; st[8'h27] = 8'h00;
      for (int i = 8'h28; i < 8'h30; i++) st[i] = 8'h00;
    end else if (wr) begin
      for (int l = 0; l < 4; l++) begin
        int a = dw*4 + l;
        if (be[l]) begin
          if ((a == 4) || (a == 5) || (a == 8'h1C) || (a == 8'h1D) ||
              (a >= 8'h20 && a <= 8'h33) || (a == 8'h3E) || (a == 8'h3F))
            exp_upd = 1'b1;
          if (a < 64) st[a] = (st[a] & ~wm(a)) | (d[8*l +: 8] & wm(a));
        end
      end
    end
    exp_srst = !old6 && st[8'h3E][6];
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit wr, input int dw, input logic [3:0] be,
                      input logic [31:0] d, input bit dis, input string req);
    cfg_wr_en   = wr;
    cfg_dw_addr = dw[5:0];
    cfg_byte_en = be;
    cfg_wdata   = d;
    fwd_disable = dis;
    #1;
    chk(req, "rdata", cfg_rdata, mread(dw));
    chk("R6", "sec_bus_rst", {31'h0, sec_bus_rst}, {31'h0, exp_srst});
    chk("R7", "win_update", {31'h0, win_update}, {31'h0, exp_upd});
    @(posedge clk);
    mupdate(wr, dw, be, d, dis);
    @(negedge clk);
    cfg_wr_en   = 1'b0;
    fwd_disable = 1'b0;
  endtask

  task automatic rd(input int dw, input string req);
    step(1'b0, dw, 4'h0, 32'h0, 1'b0, req);
  endtask

  task automatic do_reset();
    cfg_wr_en = 1'b0; fwd_disable = 1'b0;
    rst_n = 1'b0;
    mclear();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    cfg_dw_addr = '0; cfg_byte_en = '0; cfg_wdata = '0;
    @(negedge clk);
    do_reset();
    // R1, R2: reset values and constants
    for (int i = 0; i < 16; i++) rd(i, "R1");
    // R9: bus numbers and latency fully writable; R7: no strobe there
    step(1'b1, 6, 4'hF, 32'h4018_0201, 1'b0, "R9");
    rd(6, "R9");
    // R3: one lane only
    step(1'b1, 6, 4'b0010, 32'hAAAA_77BB, 1'b0, "R3");
    rd(6, "R3");
    // R4: read-only type nibbles, secondary status constant
    step(1'b1, 7, 4'hF, 32'hFFFF_FFFF, 1'b0, "R4");
    rd(7, "R4");
    step(1'b1, 8, 4'hF, 32'h1234_5678, 1'b0, "R4");
    step(1'b1, 9, 4'hF, 32'hFFFF_FFFF, 1'b0, "R4");
    rd(8, "R4");
    rd(9, "R4");
    // R9: upper registers, back-to-back strobes (R7)
    step(1'b1, 10, 4'hF, 32'hDEAD_BEEF, 1'b0, "R9");
    step(1'b1, 11, 4'hF, 32'hCAFE_F00D, 1'b0, "R9");
    step(1'b1, 12, 4'hF, 32'h0F0F_A5A5, 1'b0, "R9");
    rd(10, "R9"); rd(11, "R9"); rd(12, "R9");
    // R8: command mask, R2: status and identity unchanged
    step(1'b1, 1, 4'hF, 32'hFFFF_FFFF, 1'b0, "R8");
    rd(1, "R8");
    step(1'b1, 0, 4'hF, 32'h0000_0000, 1'b0, "R2");
    step(1'b1, 2, 4'hF, 32'h0000_0000, 1'b0, "R2");
    step(1'b1, 3, 4'hF, 32'hFFFF_FFFF, 1'b0, "R2");
    rd(0, "R2"); rd(2, "R2"); rd(3, "R2");
    // R6/R8: bridge control
    step(1'b1, 15, 4'b1100, 32'hFFFF_0000, 1'b0, "R8");
    rd(15, "R8");
    step(1'b1, 15, 4'b0100, 32'h0040_0000, 1'b0, "R6");
    step(1'b1, 15, 4'b1100, 32'h0000_0000, 1'b0, "R6");
    step(1'b1, 15, 4'b0100, 32'h0040_0000, 1'b0, "R6");
    step(1'b1, 15, 4'b1000, 32'h0500_0000, 1'b0, "R6");
    rd(15, "R6");
    // R7: bytes outside the ranges and empty enables
    step(1'b1, 15, 4'b0001, 32'h0000_00FF, 1'b0, "R7");
    step(1'b1, 8, 4'b0000, 32'hFFFF_FFFF, 1'b0, "R7");
    step(1'b1, 13, 4'hF, 32'hFFFF_FFFF, 1'b0, "R7");
    step(1'b1, 7, 4'b1100, 32'hFFFF_FFFF, 1'b0, "R7");
    rd(8, "R7");
    // R5: disable forwarding, then disable with a write in the same cycle
    step(1'b0, 7, 4'h0, 32'h0, 1'b1, "R5");
    rd(7, "R5"); rd(8, "R5"); rd(9, "R5"); rd(10, "R5"); rd(11, "R5"); rd(12, "R5");
    step(1'b1, 6, 4'hF, 32'h1111_1111, 1'b1, "R5");
    rd(6, "R5");
    // R1: reset in the middle of a run
    do_reset();
    for (int i = 0; i < 16; i++) rd(i, "R1");
    summary();
    $finish;
  end
endmodule